// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block collects thirty-two level-sensitive interrupt lines and folds them into four request lines for an upstream interrupt controller, one line per group of eight neighbouring sources. A single 32-bit enable mask selects which sources may take part. Software changes the mask through two write-only views: one that turns bits on and one that turns bits off. Bits written as zero leave the mask alone in both, so no read-modify-write is needed.

When a group line rises, software reads the status word and services the lowest-numbered pending source first, since bit 0 carries the highest priority in the bank. Each group also drives a 3-bit index of its lowest pending source, with a valid flag, so a handler can skip the bit search. The register port is synchronous: a read returns its data on the clock edge after the request.

Top module: `irq_group_combiner`

## Requirements
- R1: A write to offset 0x0 sets every enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 do not change.
- R2: A write to offset 0x4 clears every enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 do not change.
- R3: A read of offset 0x0 or 0x4 returns the enable mask as it stood before that cycle's edge. A read of any other offset except 0xC returns zero. A write to an offset other than 0x0 or 0x4 leaves the mask unchanged. `bus_rdata` is updated on the edge that samples `bus_ren` and holds its value when no read is made.
- R4: A read of offset 0xC returns the status word. The status word is registered: status bit i equals `src_level[i]` AND enable bit i, both sampled at the previous edge.
- R5: `grp_req[g]` is the OR of status bits 8g to 8g+7. It therefore follows a change of inputs or enables one clock later, and it stays high for as long as an enabled source in the group is held high.
- R6: While `rst_n` is low at a clock edge, the enables, the status word, `bus_rdata` and all group outputs go to zero.
- R7: `grp_idx[3g+2:3g]` is the position (0 to 7) of the lowest set status bit in group g, and it is 0 when the group has no set bit. `grp_idx_vld[g]` equals `grp_req[g]`.
- R8: A source whose enable bit is 0 never shows in the status word and never raises its group line, whatever its level.
- R9: Writing 0xFFFFFFFF to offset 0x4 masks every source. One cycle later all group lines and the whole status word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_ren` |
| src_level | input | 32 | Level interrupt sources; bit i is source i |
| grp_req | output | 4 | Combined request per group of eight |
| grp_idx | output | 12 | Lowest pending index per group, 3 bits each |
| grp_idx_vld | output | 4 | Index valid per group |

## Verification
A walking one is driven through all thirty-two sources with every enable set. This shows that each source reaches only its own group line and the correct index, and it catches wrong slice boundaries. Two-bit patterns inside one group are then removed one bit at a time; the index must move from the lowest bit to the next, which exposes a reversed priority encoder. Partial enable masks against all-ones inputs separate gating by enable from a plain OR of the inputs. Writes with mixed ones and zeros, including writes to unused offsets, expose a set or clear view that overwrites instead of merging. A long pseudo-random run of source levels and register accesses is compared each cycle with a behavioural model.

// File: rtl/irq_comb_pkg.sv
// Package: shared register offsets and sizing helpers for the grouped combiner.
// Assumes byte offsets on a 32-bit register bank.
package irq_comb_pkg;
    localparam int unsigned OFS_EN_SET = 32'h0;
    localparam int unsigned OFS_EN_CLR = 32'h4;
    localparam int unsigned OFS_STATUS = 32'hC;

    // Index width for a group of n sources (at least one bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/combiner_en_bank.sv
// Enable mask register with separate write-one-to-set and write-one-to-clear views.
// Assumes one write per cycle; writes to any other offset are ignored.
module combiner_en_bank
    import irq_comb_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  en_mask
);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_EN_CLR);

    logic hit_set, hit_clr;
    assign hit_set = wr_en && (addr == A_SET);
    assign hit_clr = wr_en && (addr == A_CLR);

    // Merge set or clear requests into the stored mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_mask <= '0;
        else if (hit_set)
            en_mask <= en_mask | wdata;
        else if (hit_clr)
            en_mask <= en_mask & ~wdata;
    end

    assert_set_merges_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> ((en_mask & $past(wdata)) == $past(wdata))
                 && ((en_mask & ~$past(wdata)) == ($past(en_mask) & ~$past(wdata))));

    assert_clr_merges_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clr |=> ((en_mask & $past(wdata)) == '0)
                 && ((en_mask & ~$past(wdata)) == ($past(en_mask) & ~$past(wdata))));

    assert_other_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_set || hit_clr) |=> $stable(en_mask));
endmodule

// File: rtl/combiner_group.sv
// One group: combined request and lowest-pending index over its status slice.
// Assumes the status slice is already registered and gated by enables.
module combiner_group
    import irq_comb_pkg::*;
#(
    parameter int unsigned SRC   = 8,
    parameter int unsigned IDX_W = idx_width(SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC-1:0]   pend,
    output logic             req,
    output logic [IDX_W-1:0] idx
);
    // Combined request of the group.
    assign req = |pend;

    // Priority encoder: the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int b = SRC - 1; b >= 0; b--) begin
            if (pend[b]) idx = IDX_W'(b);
        end
    end

    assert_idx_points_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> pend[idx]);

    assert_idx_is_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> ((pend & ((SRC'(1) << idx) - SRC'(1))) == '0));

    assert_idle_idx_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (idx == '0));
endmodule

// File: rtl/combiner_rd_port.sv
// Registered read mux for the enable mask and the status word.
// Assumes a one-cycle read latency; data holds between reads.
module combiner_rd_port
    import irq_comb_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  en_mask,
    input  logic [WIDTH-1:0]  status,
    output logic [WIDTH-1:0]  rdata
);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_EN_CLR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);

    logic [WIDTH-1:0] sel;
    logic             mapped;

    // Choose the word addressed; unmapped offsets read zero.
    always_comb begin
        sel    = '0;
        mapped = 1'b1;
        if (addr == A_SET || addr == A_CLR)
            sel = en_mask;
        else if (addr == A_STAT)
            sel = status;
        else
            mapped = 1'b0;
    end

    // Capture read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= sel;
    end

    assert_unmapped_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> (rdata == '0));

    assert_rdata_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: rtl/irq_group_combiner.sv
// Top: 32 level sources in four groups of eight, enable mask, registered status,
// per-group request lines and lowest-pending indices.
// Assumes the sources are already synchronous to clk.
module irq_group_combiner
    import irq_comb_pkg::*;
#(
    parameter int unsigned GROUPS  = 4,
    parameter int unsigned GRP_SRC = 8,
    parameter int unsigned ADDR_W  = 8,
    localparam int unsigned WIDTH  = GROUPS * GRP_SRC,
    localparam int unsigned IDX_W  = idx_width(GRP_SRC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wen,
    input  logic                    bus_ren,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [WIDTH-1:0]        bus_wdata,
    output logic [WIDTH-1:0]        bus_rdata,
    input  logic [WIDTH-1:0]        src_level,
    output logic [GROUPS-1:0]       grp_req,
    output logic [GROUPS*IDX_W-1:0] grp_idx,
    output logic [GROUPS-1:0]       grp_idx_vld
);
    logic [WIDTH-1:0] en_q;
    logic [WIDTH-1:0] status_q;

    combiner_en_bank #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wen),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .en_mask (en_q)
    );

    // Register the gated source levels as the status word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= src_level & en_q;
    end

    combiner_rd_port #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (bus_ren),
        .addr    (bus_addr),
        .en_mask (en_q),
        .status  (status_q),
        .rdata   (bus_rdata)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        combiner_group #(.SRC(GRP_SRC), .IDX_W(IDX_W)) u_grp (
            .clk   (clk),
            .rst_n (rst_n),
            .pend  (status_q[g*GRP_SRC +: GRP_SRC]),
            .req   (grp_req[g]),
            .idx   (grp_idx[g*IDX_W +: IDX_W])
        );

        assert_req_follows_levels_R5: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (grp_req[g] == |($past(src_level[g*GRP_SRC +: GRP_SRC])
                                     & $past(en_q[g*GRP_SRC +: GRP_SRC]))));
    end

    assign grp_idx_vld = grp_req;

    assert_disabled_never_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(en_q)) == '0));

    assert_status_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ren && bus_addr == ADDR_W'(OFS_STATUS)) |=> (bus_rdata == $past(status_q)));

    assert_mask_all_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == ADDR_W'(OFS_EN_CLR) && bus_wdata == '1) |=> ##1 (grp_req == '0));
endmodule

// File: tb/test_irq_group_combiner.sv
module test_irq_group_combiner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic        bus_ren = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_level = '0;
    logic [3:0]  grp_req;
    logic [11:0] grp_idx;
    logic [3:0]  grp_idx_vld;

    int n_chk = 0;
    int n_fail = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    // 50 MHz clock.
    always #10 clk = ~clk;

    irq_group_combiner i_irq_group_combiner (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_ren(bus_ren),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_level(src_level), .grp_req(grp_req), .grp_idx(grp_idx),
        .grp_idx_vld(grp_idx_vld)
    );

    // Behavioural reference model.
    logic [31:0] m_en = '0, m_st = '0, m_rd = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en <= '0; m_st <= '0; m_rd <= '0;
        end else begin
            if (bus_wen && bus_addr == 8'h0) m_en <= m_en | bus_wdata;
            else if (bus_wen && bus_addr == 8'h4) m_en <= m_en & ~bus_wdata;
            m_st <= src_level & m_en;
            if (bus_ren) begin
                if (bus_addr == 8'h0 || bus_addr == 8'h4) m_rd <= m_en;
                else if (bus_addr == 8'hC) m_rd <= m_st;
                else m_rd <= '0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_req(input logic [31:0] st);
        logic [3:0] r;
        for (int g = 0; g < 4; g++) r[g] = (((st >> (8*g)) & 32'hFF) != 0);
        return r;
    endfunction

    function automatic logic [11:0] exp_idx(input logic [31:0] st);
        logic [11:0] r = '0;
        for (int g = 0; g < 4; g++) begin
            int low = 0;
            for (int b = 7; b >= 0; b--) if (st[8*g+b]) low = b;
            r[3*g +: 3] = 3'(low);
        end
        return r;
    endfunction

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (model_on) begin
            chk(bus_rdata == m_rd, "R3/R4 read data", bus_rdata, m_rd);
            chk(grp_req == exp_req(m_st), "R5 group request", 32'(grp_req), 32'(exp_req(m_st)));
            chk(grp_idx == exp_idx(m_st), "R7 lowest index", 32'(grp_idx), 32'(exp_idx(m_st)));
            chk(grp_idx_vld == grp_req, "R7 index valid", 32'(grp_idx_vld), 32'(grp_req));
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); #2; bus_wen = 0; bus_ren = 0; end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #2; bus_wen = 1; bus_ren = 0; bus_addr = a; bus_wdata = d;
        @(negedge clk); #2; bus_wen = 0;
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #2; bus_ren = 1; bus_wen = 0; bus_addr = a;
        @(negedge clk); #2; bus_ren = 0;
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk); #2; src_level = v;
    endtask

    initial begin
        logic [31:0] lfsr;
        idle(3);
        chk(grp_req == 4'h0 && bus_rdata == '0, "R6 reset outputs", {28'h0, grp_req} | bus_rdata, 32'h0);
        chk(grp_idx_vld == 4'h0, "R6 reset valid", 32'(grp_idx_vld), 32'h0);
        @(negedge clk); #2; rst_n = 1;
        model_on = 1;
        set_src(32'hFFFF_FFFF);
        idle(2);
        chk(grp_req == 4'h0, "R6 enables zero after reset", 32'(grp_req), 32'h0);
        rd_expect(8'h0, 32'h0, "R6 enable mask after reset");

        wr(8'h0, 32'h0000_00A5);
        rd_expect(8'h0, 32'h0000_00A5, "R1 set merge");
        wr(8'h0, 32'h0000_0100);
        rd_expect(8'h4, 32'h0000_01A5, "R1 set keeps others / R3 alias read");
        wr(8'h4, 32'h0000_0005);
        rd_expect(8'h0, 32'h0000_01A0, "R2 clear merge");
        wr(8'h8, 32'hFFFF_FFFF);
        rd_expect(8'h0, 32'h0000_01A0, "R3 unmapped write ignored");
        rd_expect(8'h8, 32'h0, "R3 unmapped read zero");
        rd_expect(8'h10, 32'h0, "R3 unmapped read zero high");
        idle(1);
        rd_expect(8'hC, 32'h0000_01A0, "R4 R8 status gated by enable");
        chk(grp_req == 4'b0011, "R8 only enabled groups", 32'(grp_req), 32'h3);
        chk(grp_idx[2:0] == 3'd5 && grp_idx[5:3] == 3'd0, "R7 index values", 32'(grp_idx), 32'h5);

        wr(8'h0, 32'hFFFF_FFFF);
        set_src(32'h0);
        idle(2);
        for (int i = 0; i < 32; i++) begin
            set_src(32'h1 << i);
            idle(2);
            chk(grp_idx[3*(i/8) +: 3] == 3'(i % 8), "R7 walking one index", 32'(grp_idx), 32'(i % 8));
        end
        set_src(32'h0000_0300);
        idle(2);
        chk(grp_req == 4'b0010 && grp_idx[5:3] == 3'd0, "R7 lowest of two", 32'(grp_idx), 32'h0);
        set_src(32'h0000_0200);
        idle(2);
        chk(grp_idx[5:3] == 3'd1, "R7 next after drop", 32'(grp_idx[5:3]), 32'h1);
        chk(grp_req == 4'b0010, "R5 level held", 32'(grp_req), 32'h2);
        set_src(32'h8040_2010);
        idle(3);
        rd_expect(8'hC, 32'h8040_2010, "R4 status pattern");
        wr(8'h4, 32'hFFFF_FFFF);
        idle(2);
        chk(grp_req == 4'h0, "R9 mask all", 32'(grp_req), 32'h0);
        rd_expect(8'hC, 32'h0, "R9 status cleared");

        lfsr = 32'hACE1_2345;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            @(negedge clk); #2;
            src_level = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            bus_wen   = lfsr[3] & ~lfsr[4];
            bus_ren   = lfsr[5];
            bus_addr  = {4'h0, lfsr[9:8], 2'b00};
            bus_wdata = {lfsr[7:0], lfsr[31:8]};
        end
        idle(3);
        model_on = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule